// File: doc/BRIEF.md
# Conditional Trap Compare Unit

This unit decides whether a conditional trap instruction should fire. It compares two 64-bit operands and tests five relations: signed less-than, signed greater-than, equality, unsigned less-than and unsigned greater-than. A 5-bit condition mask enables each relation separately. When at least one enabled relation holds on a valid cycle, the unit raises a one-cycle registered trap request. Alongside the request it gives a fixed program-exception sub-cause code that identifies the cause as a trap.

A width select chooses between two compare modes. In word mode only the low 32 bits of each operand take part, under both the signed and the unsigned reading. In doubleword mode all 64 bits are used. Instruction decode and the exception entry sequence sit outside this block.

Top module: `trap_cmp`

## Requirements
- R1: After reset, and in every cycle with no valid strobe on the previous edge, `trap_o` is 0.
- R2: Mask bit 4 (value 0x10) enables a trap when operand A is less than operand B as signed values.
- R3: Mask bit 3 (value 0x08) enables a trap when A is greater than B as signed values.
- R4: Mask bit 2 (value 0x04) enables a trap when A equals B.
- R5: Mask bit 1 (value 0x02) enables a trap when A is less than B as unsigned values. Mask bit 0 (value 0x01) enables a trap when A is greater than B as unsigned values.
- R6: `trap_o` is the OR of all enabled relations. It is registered, so it goes high on the clock edge after the edge that samples `valid_i`, and it lasts one cycle for each valid cycle.
- R7: With `dword_i`=0, only bits 31:0 of each operand are compared, as 32-bit signed and unsigned values, and bits 63:32 have no effect. With `dword_i`=1, all 64 bits are compared.
- R8: A mask of 0x00 never traps. A mask of 0x1F always traps on a valid cycle.
- R9: `cause_o` is always the constant trap sub-cause code 4'h3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Evaluate the condition this cycle |
| dword_i | input | 1 | 1 = 64-bit compare, 0 = 32-bit compare |
| mask_i | input | 5 | Condition mask: bit 4 signed lt, bit 3 signed gt, bit 2 eq, bit 1 unsigned lt, bit 0 unsigned gt |
| opa_i | input | 64 | Operand A |
| opb_i | input | 64 | Operand B |
| trap_o | output | 1 | Registered trap request, one cycle |
| cause_o | output | 4 | Program-exception sub-cause, fixed at trap (4'h3) |

## Verification
The hardest case is one where the signed and unsigned orderings disagree, and where in word mode the upper halves would give a different answer from the lower halves. Vectors place the sign bit of bit 31 or bit 63 in one operand only, which splits the signed and unsigned results. They then fill bits 63:32 with data that points the other way, so a design that compared the full width, or sign-extended from the wrong bit, fails. Each such vector runs under a single-relation mask, so every relation is checked on its own.

// File: rtl/trap_cmp.sv
module trap_cmp #(
  parameter int W = 64,
  parameter int HW = 32,
  parameter logic [3:0] TRAP_CAUSE = 4'h3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid_i,
  input  logic         dword_i,
  input  logic [4:0]   mask_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  output logic         trap_o,
  output logic [3:0]   cause_o
);
  logic [W-1:0] a, b;
  logic slt, sgt, eq, ult, ugt, hit;

  assign a = dword_i ? opa_i : {{(W-HW){opa_i[HW-1]}}, opa_i[HW-1:0]};
  assign b = dword_i ? opb_i : {{(W-HW){opb_i[HW-1]}}, opb_i[HW-1:0]};

  assign slt = $signed(a) < $signed(b);
  assign sgt = $signed(a) > $signed(b);
  assign eq  = a == b;
  assign ult = a < b;
  assign ugt = a > b;

  assign hit = |(mask_i & {slt, sgt, eq, ult, ugt});

  always_ff @(posedge clk) begin
    if (!rst_n) trap_o <= 1'b0;
    else        trap_o <= valid_i & hit;
  end

  assign cause_o = TRAP_CAUSE;

  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> !trap_o);
  assert_zero_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && mask_i == 5'd0) |=> !trap_o);
  assert_full_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && mask_i == 5'h1F) |=> trap_o);
  assert_eq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && mask_i[2] && opa_i == opb_i) |=> trap_o);
  assert_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({slt, sgt, eq}) == 1 && $countones({ult, ugt, eq}) == 1);
  assert_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cause_o == 4'h3);
endmodule

// File: tb/trap_cmp_bench.sv
module trap_cmp_bench;
  logic clk = 0, rst_n = 0, valid = 0, dword = 0;
  logic [4:0] mask = 0;
  logic [63:0] a = 0, b = 0;
  logic trap;
  logic [3:0] cause;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  trap_cmp u_trap_cmp (.clk(clk), .rst_n(rst_n), .valid_i(valid), .dword_i(dword),
    .mask_i(mask), .opa_i(a), .opb_i(b), .trap_o(trap), .cause_o(cause));

  typedef struct packed { logic dw; logic [4:0] m; logic [63:0] x; logic [63:0] y; logic e; } vec_t;
  localparam int N = 18;
  localparam vec_t V [N] = '{
    '{1'b1, 5'h10, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1'b1},               // R2 -1<1
    '{1'b1, 5'h02, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1'b0},               // R5 big !< 1
    '{1'b1, 5'h01, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1'b1},               // R5 ugt
    '{1'b1, 5'h08, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1'b0},               // R3
    '{1'b1, 5'h08, 64'd7, 64'h8000_0000_0000_0000, 1'b1},               // R3
    '{1'b1, 5'h04, 64'h1234_0000_0000_5678, 64'h1234_0000_0000_5678, 1'b1}, // R4
    '{1'b1, 5'h04, 64'h1234_0000_0000_5678, 64'h1234_0000_0000_5679, 1'b0}, // R4
    '{1'b1, 5'h1B, 64'd9, 64'd9, 1'b0},                                 // R6 eq off
    '{1'b1, 5'h03, 64'd3, 64'd4, 1'b1},                                 // R6 or
    '{1'b0, 5'h10, 64'h0000_0005_8000_0000, 64'h0000_0000_0000_0001, 1'b1}, // R7 word signed
    '{1'b0, 5'h01, 64'h0000_0005_8000_0000, 64'h0000_0000_0000_0001, 1'b1}, // R7 word unsigned
    '{1'b1, 5'h10, 64'h0000_0005_8000_0000, 64'h0000_0000_0000_0001, 1'b0}, // R7 dword
    '{1'b0, 5'h04, 64'hAAAA_AAAA_0000_0042, 64'h5555_5555_0000_0042, 1'b1}, // R7 upper ignored
    '{1'b1, 5'h04, 64'hAAAA_AAAA_0000_0042, 64'h5555_5555_0000_0042, 1'b0}, // R7
    '{1'b0, 5'h02, 64'hFFFF_FFFF_0000_0001, 64'h0000_0000_0000_0002, 1'b1}, // R7 ult word
    '{1'b1, 5'h00, 64'd1, 64'd2, 1'b0},                                 // R8
    '{1'b0, 5'h1F, 64'd77, 64'd77, 1'b1},                               // R8
    '{1'b1, 5'h1F, 64'h8000_0000_0000_0000, 64'd0, 1'b1}                // R8
  };

  task automatic chk(input logic got, input logic exp, input string req);
    total++;
    if (got !== exp) begin bad++; $display("FAIL %s: got=%0b exp=%0b", req, got, exp); end
  endtask

  task automatic run(input logic dw, input logic [4:0] m, input logic [63:0] x, input logic [63:0] y,
                     input logic e, input string req);
    @(negedge clk); valid = 1; dword = dw; mask = m; a = x; b = y;
    @(negedge clk); valid = 0; a = ~x; b = y;
    chk(trap, e, req);
    @(negedge clk); chk(trap, 1'b0, "R6 single cycle");
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog: got=hang exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(trap, 1'b0, "R1 reset");
    total++; if (cause !== 4'h3) begin bad++; $display("FAIL R9: got=%h exp=3", cause); end
    rst_n = 1;
    for (int i = 0; i < N; i++) run(V[i].dw, V[i].m, V[i].x, V[i].y, V[i].e, "R2-vector");
    // no valid: R1
    @(negedge clk); valid = 0; mask = 5'h1F; a = 0; b = 0;
    @(negedge clk); chk(trap, 1'b0, "R1 no valid");
    // back to back valid cycles: R6
    @(negedge clk); valid = 1; dword = 1; mask = 5'h04; a = 5; b = 5;
    @(negedge clk); b = 6;
    chk(trap, 1'b1, "R6 first");
    @(negedge clk); valid = 0;
    chk(trap, 1'b0, "R6 second");
    total++; if (cause !== 4'h3) begin bad++; $display("FAIL R9: got=%h exp=3", cause); end
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule